// File: doc/BRIEF.md
# Qualified AHB Register Target with Wait States

This block is the slave side of a small register target on an AHB-style shared bus. On every clock it decides whether the address phase now on the bus is a committed transfer addressed to it. A transfer is committed only when three things hold in the same cycle: the transfer type is a real one, the select line is high, and the shared bus-ready input is high. Every other cycle is treated as a non-event. On a non-event the block changes no register and answers OKAY.

When a transfer commits, the block captures the address, direction and size. It then runs the data phase against a bank of word registers. The data phase stalls the bus for a configurable number of wait cycles before it completes.

One register holds sticky flags recording which registers have been written. Reading it returns the flags and clears them, so a read that did not commit must never reach it. The bus-ready term always comes from the shared input and never from the block's own ready output. A slow neighbour that holds the bus therefore delays this block's transfer until the bus actually advances. The interface is plain bus control rather than valid/ready streaming: back-pressure is expressed only by the block lowering `ready_out` during its own data phase.

Top module: `ahbq_target`

## Requirements
- R1: After reset `ready_out` is 1, `resp_err` is 0, `rdata` is 0, and every register and status flag reads as 0.
- R2: A transfer commits only when `trans_type` is NONSEQ (2'b10) or SEQ (2'b11), `slot_sel` is 1 and `bus_ready` is 1 in the same cycle. An IDLE (2'b00) or BUSY (2'b01) cycle writes nothing, clears nothing, and leaves `ready_out` high.
- R3: With `slot_sel` low, nothing is written or cleared and `ready_out` stays high, even when `trans_type` is real and `bus_ready` is high.
- R4: While `bus_ready` is low, a selected real transfer is not captured. It commits only on the cycle `bus_ready` is high, and an address withdrawn before then has no effect.
- R5: After a commit, `ready_out` is low for exactly WAIT_N data-phase cycles and high on the final data-phase cycle.
- R6: On the final cycle of a committed read, `rdata` holds the addressed register. At all other times `rdata` is 0.
- R7: Writes update only the byte lanes selected by the captured size (0 = byte, 1 = halfword, 2 = word) and the captured address bits [1:0], taking the data from `wdata` on the final data-phase cycle.
- R8: The register at byte offset 0x4 is the status register. Its bit k is set when register k (offset 4k, k ≠ 1) is written. A committed read of 0x4 returns the flags and clears them. Writes to 0x4 are ignored and set no flag.
- R9: `resp_err` is 0 (OKAY) in every cycle.
- R10: The data phase uses the address, direction and size captured at commit, whatever `addr`, `wr_en` and `xfer_size` do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trans_type | input | 2 | Transfer type: IDLE, BUSY, NONSEQ, SEQ |
| slot_sel | input | 1 | Decoder select for this target |
| bus_ready | input | 1 | Shared bus-ready, high when the bus advances |
| addr | input | ADDR_W | Address-phase byte address |
| wr_en | input | 1 | Address-phase direction, 1 = write |
| xfer_size | input | 3 | Address-phase transfer size |
| wdata | input | DATA_W | Write data, valid in the data phase |
| rdata | output | DATA_W | Read data, valid on the final data-phase cycle |
| ready_out | output | 1 | Low while this target stalls its data phase |
| resp_err | output | 1 | Response, always OKAY (0) |

## Verification
The assertions assume a bus that follows the usual pipelining: `bus_ready` is never high while this target holds `ready_out` low in its own data phase, and a write's `wdata` is stable until the data phase ends. The bench ties `bus_ready` to `ready_out`, gated by a separate neighbour-stall signal. It raises that stall signal only while no data phase of this target is active. It holds each address phase for exactly one advancing cycle before returning the bus to IDLE.

// File: rtl/ahbq_pkg.sv
package ahbq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  // Byte-lane enables for a naturally aligned access of 2**size bytes.
  function automatic logic [7:0] lane_mask(input logic [2:0] size,
                                           input logic [2:0] off,
                                           input int lanes);
    int nb;
    int base;
    logic [15:0] ones;
    nb = 1 << size;
    if (nb > lanes) nb = lanes;
    base = int'(off) & ~(nb - 1) & (lanes - 1);
    ones = (16'd1 << nb) - 16'd1;
    return ones[7:0] << base;
  endfunction

endpackage

// File: rtl/ahbq_qualify.sv
module ahbq_qualify #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trans_type,
  input  logic              slot_sel,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [2:0]        xfer_size,
  output logic              commit,
  output logic [ADDR_W-1:0] cap_addr,
  output logic              cap_write,
  output logic [2:0]        cap_size
);
  import ahbq_pkg::*;

  logic real_xfer;

  always_comb begin
    real_xfer = (trans_type == TR_NONSEQ) || (trans_type == TR_SEQ);
    commit    = real_xfer && slot_sel && bus_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_write <= 1'b0;
      cap_size  <= '0;
    end else if (commit) begin
      cap_addr  <= addr;
      cap_write <= wr_en;
      cap_size  <= xfer_size;
    end
  end

  // R4: nothing is captured while the shared bus is stalled
  a_r4_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |=> ($stable(cap_addr) && $stable(cap_write) && $stable(cap_size)));

  // R2: an IDLE or BUSY cycle captures nothing
  a_r2_no_capture_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !trans_type[1] |=> $stable(cap_addr));

endmodule

// File: rtl/ahbq_wait_ctrl.sv
module ahbq_wait_ctrl #(
  parameter int WAIT_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  output logic in_data,
  output logic last,
  output logic ready_out
);
  localparam int CNT_W = (WAIT_N < 1) ? 1 : $clog2(WAIT_N + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WAIT_N);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= 1'b0;
      cnt_q   <= '0;
    end else if (commit) begin
      in_data <= 1'b1;
      cnt_q   <= LOAD;
    end else if (in_data && cnt_q != '0) begin
      cnt_q   <= cnt_q - 1'b1;
    end else begin
      in_data <= 1'b0;
    end
  end

  always_comb begin
    last      = in_data && (cnt_q == '0);
    ready_out = !(in_data && (cnt_q != '0));
  end

  // R5: the first data-phase cycle stalls unless no wait states are configured
  a_r5_commit_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (ready_out == (WAIT_N == 0)));

  // R5: every stalled cycle moves one step closer to completion
  a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && cnt_q != '0 && !commit) |=> (in_data && cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ahbq_regbank.sv
module ahbq_regbank #(
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 4,
  parameter int STATUS_IDX = 1,
  localparam int IDX_W     = $clog2(NUM_REGS),
  localparam int LANES     = DATA_W / 8,
  localparam int OFF_W     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              last,
  input  logic              is_write,
  input  logic [IDX_W-1:0]  idx,
  input  logic [2:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  import ahbq_pkg::*;

  localparam logic [IDX_W-1:0] ST = IDX_W'(STATUS_IDX);

  logic                do_wr;
  logic                do_rd;
  logic [7:0]          mask8;
  logic [LANES-1:0]    lane_en;
  logic [NUM_REGS-1:0] wr_hit;
  logic [NUM_REGS-1:0] status_q;
  logic [DATA_W-1:0]   reg_view [NUM_REGS];

  always_comb begin
    do_wr   = last && is_write;
    do_rd   = last && !is_write;
    mask8   = lane_mask(size, 3'(off), LANES);
    lane_en = mask8[LANES-1:0];
    for (int k = 0; k < NUM_REGS; k++) begin
      wr_hit[k] = do_wr && (idx == IDX_W'(k)) && (k != STATUS_IDX);
    end
  end

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    if (k == STATUS_IDX) begin : g_stat
      assign reg_view[k] = DATA_W'(status_q);
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_hit[k]) begin
          for (int b = 0; b < LANES; b++) begin
            if (lane_en[b]) q[8*b +: 8] <= wdata[8*b +: 8];
          end
        end
      end
      assign reg_view[k] = q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (do_rd && idx == ST) begin
      status_q <= '0;
    end else begin
      status_q <= status_q | wr_hit;
    end
  end

  assign rdata = do_rd ? reg_view[idx] : '0;

  // R8: a completed read of the status register leaves it clear
  a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (do_rd && idx == ST) |=> (status_q == '0));

  // R2: flags move only when a data phase completes
  a_r2_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(status_q));

  // R8: a write to the status offset sets no flag
  a_r8_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && idx == ST) |=> $stable(status_q));

endmodule

// File: rtl/ahbq_target.sv
module ahbq_target #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int NUM_REGS   = 4,
  parameter int STATUS_IDX = 1,
  parameter int WAIT_N     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        trans_type,
  input  logic              slot_sel,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [2:0]        xfer_size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready_out,
  output logic              resp_err
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic              commit;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_write;
  logic [2:0]        cap_size;
  logic              in_data;
  logic              last;

  ahbq_qualify #(.ADDR_W(ADDR_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .trans_type(trans_type), .slot_sel(slot_sel),
    .bus_ready(bus_ready), .addr(addr), .wr_en(wr_en), .xfer_size(xfer_size),
    .commit(commit), .cap_addr(cap_addr), .cap_write(cap_write), .cap_size(cap_size)
  );

  ahbq_wait_ctrl #(.WAIT_N(WAIT_N)) u_wait (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .in_data(in_data), .last(last), .ready_out(ready_out)
  );

  ahbq_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .STATUS_IDX(STATUS_IDX)) u_bank (
    .clk(clk), .rst_n(rst_n), .last(last), .is_write(cap_write),
    .idx(cap_addr[OFF_W +: IDX_W]), .size(cap_size), .off(cap_addr[OFF_W-1:0]),
    .wdata(wdata), .rdata(rdata)
  );

  assign resp_err = 1'b0;

  // R3: without a selected real transfer on an advancing bus, a ready target stays ready
  a_r3_unselected_stays_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_out && !(slot_sel && trans_type[1] && bus_ready)) |=> ready_out);

  // R6: read data appears only when the bus is being released
  a_r6_rdata_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_out |-> (rdata == '0));

endmodule

// File: tb/ahbq_target_tb_top.sv
module ahbq_target_tb_top;
  localparam int WAIT_N = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  trans_type = 2'b00;
  logic        slot_sel = 1'b0;
  logic        peer_stall = 1'b0;
  logic        bus_ready;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  xfer_size = 3'd2;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready_out;
  logic        resp_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  assign bus_ready = ready_out && !peer_stall;

  ahbq_target #(.WAIT_N(WAIT_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .trans_type(trans_type), .slot_sel(slot_sel),
    .bus_ready(bus_ready), .addr(addr), .wr_en(wr_en), .xfer_size(xfer_size),
    .wdata(wdata), .rdata(rdata), .ready_out(ready_out), .resp_err(resp_err)
  );

  typedef struct packed {
    logic       sel;
    logic [1:0] tr;
    logic       wr;
    logic [7:0] off;
    logic [2:0] size;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [3:0] exp_wait;
    logic [3:0] tag;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 1'b1, 8'h00, 3'd2, 32'hA5A50001, 32'h0,        4'd2, 4'd5},  // R5 word write reg0
    '{1'b1, 2'd2, 1'b0, 8'h00, 3'd2, 32'h0,        32'hA5A50001, 4'd2, 4'd6},  // R6 read reg0
    '{1'b1, 2'd2, 1'b1, 8'h02, 3'd1, 32'hBEEF0000, 32'h0,        4'd2, 4'd7},  // R7 upper halfword
    '{1'b1, 2'd3, 1'b0, 8'h00, 3'd2, 32'h0,        32'hBEEF0001, 4'd2, 4'd7},  // R7 readback
    '{1'b1, 2'd0, 1'b1, 8'h08, 3'd2, 32'h11111111, 32'h0,        4'd0, 4'd2},  // R2 IDLE write
    '{1'b1, 2'd1, 1'b1, 8'h08, 3'd2, 32'h22222222, 32'h0,        4'd0, 4'd2},  // R2 BUSY write
    '{1'b0, 2'd2, 1'b1, 8'h08, 3'd2, 32'h33333333, 32'h0,        4'd0, 4'd3},  // R3 unselected write
    '{1'b1, 2'd3, 1'b0, 8'h08, 3'd2, 32'h0,        32'h0,        4'd2, 4'd1},  // R1 reg2 untouched
    '{1'b1, 2'd2, 1'b0, 8'h04, 3'd2, 32'h0,        32'h00000001, 4'd2, 4'd8},  // R8 flag reg0
    '{1'b1, 2'd2, 1'b0, 8'h04, 3'd2, 32'h0,        32'h0,        4'd2, 4'd8},  // R8 cleared
    '{1'b1, 2'd2, 1'b1, 8'h0E, 3'd0, 32'h00CC0000, 32'h0,        4'd2, 4'd7},  // R7 byte lane 2
    '{1'b1, 2'd3, 1'b1, 8'h0C, 3'd1, 32'h12345678, 32'h0,        4'd2, 4'd7},  // R7 low halfword
    '{1'b1, 2'd2, 1'b0, 8'h0C, 3'd2, 32'h0,        32'h00CC5678, 4'd2, 4'd7},  // R7 merged
    '{1'b1, 2'd0, 1'b0, 8'h04, 3'd2, 32'h0,        32'h0,        4'd0, 4'd2},  // R2 IDLE status read
    '{1'b0, 2'd2, 1'b0, 8'h04, 3'd2, 32'h0,        32'h0,        4'd0, 4'd3},  // R3 unselected status read
    '{1'b1, 2'd2, 1'b0, 8'h04, 3'd2, 32'h0,        32'h00000008, 4'd2, 4'd8},  // R8 flag reg3 kept
    '{1'b1, 2'd2, 1'b1, 8'h04, 3'd2, 32'hFFFFFFFF, 32'h0,        4'd2, 4'd8},  // R8 write ignored
    '{1'b1, 2'd2, 1'b0, 8'h04, 3'd2, 32'h0,        32'h0,        4'd2, 4'd8}   // R8 still clear
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One address phase, then the data phase with the bus released to IDLE (R10).
  task automatic xfer(input logic sel, input logic [1:0] tr, input logic wr,
                      input logic [7:0] off, input logic [2:0] sz, input logic [31:0] wd,
                      output logic [31:0] rd, output int waits);
    @(negedge clk);
    slot_sel = sel; trans_type = tr; wr_en = wr; addr = {4'h0, off}; xfer_size = sz;
    @(negedge clk);
    slot_sel = 1'b0; trans_type = 2'b00; wr_en = !wr; addr = 12'h008; xfer_size = 3'd0;
    wdata = wd;
    waits = 0;
    while (!ready_out) begin
      check(resp_err == 1'b0, "R9 resp during stall", 32'(resp_err), 32'h0);
      waits++;
      @(negedge clk);
    end
    rd = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int w;
    repeat (3) @(negedge clk);
    check(ready_out == 1'b1, "R1 ready in reset", 32'(ready_out), 32'h1);
    check(resp_err == 1'b0, "R1 resp in reset", 32'(resp_err), 32'h0);
    check(rdata == 32'h0, "R1 rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready_out == 1'b1, "R1 ready after reset", 32'(ready_out), 32'h1);

    for (int i = 0; i < NV; i++) begin
      xfer(VEC[i].sel, VEC[i].tr, VEC[i].wr, VEC[i].off, VEC[i].size, VEC[i].wd, rd, w);
      check(rd == VEC[i].exp_rd, $sformatf("R%0d rdata vec %0d", VEC[i].tag, i),
            rd, VEC[i].exp_rd);
      check(w == int'(VEC[i].exp_wait), $sformatf("R5 wait count vec %0d", i),
            32'(w), 32'(VEC[i].exp_wait));
      check(resp_err == 1'b0, "R9 resp okay", 32'(resp_err), 32'h0);
    end

    // R4: write offered during a neighbour stall, then withdrawn
    @(negedge clk);
    slot_sel = 1'b1; trans_type = 2'b10; wr_en = 1'b1; addr = 12'h008; xfer_size = 3'd2;
    wdata = 32'h0000DEAD; peer_stall = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(ready_out == 1'b1, "R4 no data phase while stalled", 32'(ready_out), 32'h1);
    end
    slot_sel = 1'b0; trans_type = 2'b00; peer_stall = 1'b0;
    xfer(1'b1, 2'b10, 1'b0, 8'h08, 3'd2, 32'h0, rd, w);
    check(rd == 32'h0, "R4 withdrawn write ignored", rd, 32'h0);

    // R4: write held through a stall commits when the bus advances
    @(negedge clk);
    slot_sel = 1'b1; trans_type = 2'b10; wr_en = 1'b1; addr = 12'h008; xfer_size = 3'd2;
    peer_stall = 1'b1;
    repeat (2) @(negedge clk);
    peer_stall = 1'b0;
    @(negedge clk);
    slot_sel = 1'b0; trans_type = 2'b00; wdata = 32'h00000055;
    check(ready_out == 1'b0, "R4 data phase after release", 32'(ready_out), 32'h0);
    while (!ready_out) @(negedge clk);
    xfer(1'b1, 2'b10, 1'b0, 8'h08, 3'd2, 32'h0, rd, w);
    check(rd == 32'h00000055, "R4 held write landed", rd, 32'h00000055);
    xfer(1'b1, 2'b10, 1'b0, 8'h04, 3'd2, 32'h0, rd, w);
    check(rd == 32'h00000004, "R8 flag reg2", rd, 32'h00000004);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule